// File: doc/BRIEF.md
# Machine Check Exception Controller

This block sits between the core's bus interface and its exception sequencer. When the internal bus flags a machine check, whether on the address phase or the data phase, the controller decides what the core does next. The error may come from a nonexistent address or from a data error. The decision uses the machine-check-enable bit of the current machine state and a debug-enable input.

If machine checks are enabled, the controller takes the interrupt. It captures the save/restore images and the new machine state, and it computes the handler vector. If they are disabled and debug is enabled, the core is sent into debug mode. Otherwise the core stops in a checkstop state, and a request goes to the reset controller.

Debug and checkstop are both sticky. Only a reset brings the block back to run. Frame outputs keep their last captured values until the next taken interrupt.

Bit naming follows the architectural convention, where architectural bit k of a 32-bit word is vector index 31-k. Machine state fields use these vector indices:

| Field | Vector index |
|---|---|
| LE | 0 |
| RI | 1 |
| IP | 6 |
| ME | 12 |
| ILE | 16 |

Top module: `mce_ctrl`

## Requirements
- R1: An indication on `mc_addr_phase_i`, on `mc_data_phase_i`, or on both in the same cycle counts as exactly one machine check event.
- R2: In run state with `msr_i[12]` (ME) = 1, an event gives a one-cycle `take_o` pulse in the cycle after the triggering edge, and the state stays run.
- R3: In run state with ME = 0 and `dbg_en_i` = 1, an event raises `debug_o` and holds it high, with a one-cycle `debug_enter_o` pulse and no `take_o`.
- R4: In run state with ME = 0 and `dbg_en_i` = 0, an event raises `checkstop_o` and holds it high, with a one-cycle `reset_req_o` pulse and no `take_o`.
- R5: On a taken interrupt, `srr0_o` equals the `fault_ea_i` of the triggering cycle.
- R6: On a taken interrupt, `srr1_o[30]` is 1 for an instruction-fetch error (`fault_fetch_i` = 1) and 0 for load/store. `srr1_o[15:0]` equals `msr_i[15:0]`. All other bits (31, 29:16) are 0.
- R7: On a taken interrupt, `msr_o[6]` (IP) and `msr_o[12]` (ME) copy `msr_i`. `msr_o[0]` (LE) copies `msr_i[16]` (ILE). All other bits are 0.
- R8: On a taken interrupt, `vector_o` is 0x00000200 when `msr_i[6]` = 0 and 0xFFF00200 when it is 1.
- R9: In debug or checkstop state, further indications are ignored. No pulse is produced and the frame outputs do not change.
- R10: After reset, the block is in run state, every output is 0, and a checkstop or debug state is cleared.
- R11: Frame outputs hold their values on cycles without a taken interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mc_addr_phase_i | input | 1 | Machine check flagged on address phase |
| mc_data_phase_i | input | 1 | Machine check flagged on data phase |
| fault_fetch_i | input | 1 | 1: instruction-fetch error, 0: load/store error |
| fault_ea_i | input | 32 | Effective address of the faulting instruction |
| msr_i | input | 32 | Current machine state |
| dbg_en_i | input | 1 | Debug mode enabled |
| srr0_o | output | 32 | Captured save/restore register 0 image |
| srr1_o | output | 32 | Captured save/restore register 1 image |
| msr_o | output | 32 | New machine state for the handler |
| vector_o | output | 32 | Handler fetch address |
| take_o | output | 1 | One-cycle pulse: interrupt taken |
| debug_o | output | 1 | Debug state held |
| debug_enter_o | output | 1 | One-cycle pulse on debug entry |
| checkstop_o | output | 1 | Checkstop state held |
| reset_req_o | output | 1 | One-cycle pulse to the reset controller on checkstop entry |

## Verification
The assertions check the following on every cycle:
- a taken event lands in `srr0_o` one cycle later;
- at most one outcome pulse occurs at a time;
- the sticky states never release without reset;
- the non-retained machine state bits stay clear;
- nothing changes while the block is halted.

Only the bench scenarios can show the per-mode outcome choice under both debug settings, the exact field layouts across random machine states, and the vector selection. They also show that reset recovers from debug and checkstop, and that the two bus phases merge into a single event.

// File: rtl/mce_pkg.sv
package mce_pkg;
    localparam int unsigned WORD_W = 32;

    // vector indices (architectural bit k -> index 31-k)
    localparam int unsigned MSR_LE  = 0;
    localparam int unsigned MSR_RI  = 1;
    localparam int unsigned MSR_IP  = 6;
    localparam int unsigned MSR_ME  = 12;
    localparam int unsigned MSR_ILE = 16;
    localparam int unsigned SRR1_FETCH = 30;
    localparam int unsigned LOW_HALF_W = 16;

    typedef enum logic [1:0] {
        MCE_RUN   = 2'd0,
        MCE_DEBUG = 2'd1,
        MCE_CSTOP = 2'd2
    } mce_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] srr0;
        logic [WORD_W-1:0] srr1;
        logic [WORD_W-1:0] msr;
        logic [WORD_W-1:0] vec;
    } mce_frame_t;

    typedef struct packed {
        mce_state_e state;
        logic       take;
        logic       dbg_enter;
        logic       cstop_req;
    } mce_ctl_t;
endpackage

// File: rtl/mce_event_sense.sv
module mce_event_sense
    import mce_pkg::*;
#(
    parameter int unsigned N_SRC = 2
) (
    input  logic [N_SRC-1:0] src_i,
    input  mce_state_e       state_i,
    output logic             evt_o
);
    logic any_src;

    // OR-reduce all phase sources into a single event
    always_comb begin
        any_src = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            any_src = any_src | src_i[i];
        end
        evt_o = any_src && (state_i == MCE_RUN);
    end
endmodule

// File: rtl/mce_frame_build.sv
module mce_frame_build
    import mce_pkg::*;
#(
    parameter logic [WORD_W-1:0] VEC_OFFSET  = 32'h0000_0200,
    parameter logic [WORD_W-1:0] HIGH_PREFIX = 32'hFFF0_0000
) (
    input  logic [WORD_W-1:0] ea_i,
    input  logic [WORD_W-1:0] msr_i,
    input  logic              fetch_i,
    output mce_frame_t        frame_o
);
    localparam int unsigned HI_W = WORD_W - LOW_HALF_W;

    logic [HI_W-1:0]   srr1_hi;
    logic [WORD_W-1:0] keep_mask;
    logic [WORD_W-1:0] base;

    always_comb begin
        srr1_hi = '0;
        srr1_hi[SRR1_FETCH-LOW_HALF_W] = fetch_i;

        keep_mask = '0;
        keep_mask[MSR_IP] = 1'b1;
        keep_mask[MSR_ME] = 1'b1;

        base = msr_i[MSR_IP] ? HIGH_PREFIX : '0;

        frame_o.srr0 = ea_i;
        frame_o.srr1 = {srr1_hi, msr_i[LOW_HALF_W-1:0]};
        frame_o.msr  = msr_i & keep_mask;
        frame_o.msr[MSR_LE] = msr_i[MSR_ILE];
        frame_o.vec  = base | VEC_OFFSET;
    end
endmodule

// File: rtl/mce_mode_ctrl.sv
module mce_mode_ctrl
    import mce_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt_i,
    input  logic       me_i,
    input  logic       dbg_en_i,
    output mce_state_e state_o,
    output logic       take_now_o,
    output logic       take_o,
    output logic       dbg_enter_o,
    output logic       cstop_req_o
);
    mce_ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.take      = 1'b0;
        ctl_d.dbg_enter = 1'b0;
        ctl_d.cstop_req = 1'b0;
        if (evt_i && ctl_q.state == MCE_RUN) begin
            if (me_i) begin
                ctl_d.take = 1'b1;
            end else if (dbg_en_i) begin
                ctl_d.state     = MCE_DEBUG;
                ctl_d.dbg_enter = 1'b1;
            end else begin
                ctl_d.state     = MCE_CSTOP;
                ctl_d.cstop_req = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{state: MCE_RUN, take: 1'b0, dbg_enter: 1'b0, cstop_req: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign state_o     = ctl_q.state;
    assign take_now_o  = ctl_d.take;
    assign take_o      = ctl_q.take;
    assign dbg_enter_o = ctl_q.dbg_enter;
    assign cstop_req_o = ctl_q.cstop_req;

    // R4
    cstop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == MCE_CSTOP) |=> (ctl_q.state == MCE_CSTOP));

    // R3
    debug_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == MCE_DEBUG) |=> (ctl_q.state == MCE_DEBUG));

    // R2
    single_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctl_q.take, ctl_q.dbg_enter, ctl_q.cstop_req}));
endmodule

// File: rtl/mce_ctrl.sv
module mce_ctrl
    import mce_pkg::*;
#(
    parameter logic [31:0] VEC_OFFSET  = 32'h0000_0200,
    parameter logic [31:0] HIGH_PREFIX = 32'hFFF0_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mc_addr_phase_i,
    input  logic        mc_data_phase_i,
    input  logic        fault_fetch_i,
    input  logic [31:0] fault_ea_i,
    input  logic [31:0] msr_i,
    input  logic        dbg_en_i,
    output logic [31:0] srr0_o,
    output logic [31:0] srr1_o,
    output logic [31:0] msr_o,
    output logic [31:0] vector_o,
    output logic        take_o,
    output logic        debug_o,
    output logic        debug_enter_o,
    output logic        checkstop_o,
    output logic        reset_req_o
);
    mce_state_e state;
    logic       evt;
    logic       take_now;
    mce_frame_t frame_new;
    mce_frame_t frame_d, frame_q;

    mce_event_sense #(.N_SRC(2)) u_sense (
        .src_i   ({mc_data_phase_i, mc_addr_phase_i}),
        .state_i (state),
        .evt_o   (evt)
    );

    mce_mode_ctrl u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt),
        .me_i        (msr_i[MSR_ME]),
        .dbg_en_i    (dbg_en_i),
        .state_o     (state),
        .take_now_o  (take_now),
        .take_o      (take_o),
        .dbg_enter_o (debug_enter_o),
        .cstop_req_o (reset_req_o)
    );

    mce_frame_build #(
        .VEC_OFFSET  (VEC_OFFSET),
        .HIGH_PREFIX (HIGH_PREFIX)
    ) u_frame (
        .ea_i    (fault_ea_i),
        .msr_i   (msr_i),
        .fetch_i (fault_fetch_i),
        .frame_o (frame_new)
    );

    always_comb begin
        frame_d = frame_q;
        if (take_now) begin
            frame_d = frame_new;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else begin
            frame_q <= frame_d;
        end
    end

    assign srr0_o      = frame_q.srr0;
    assign srr1_o      = frame_q.srr1;
    assign msr_o       = frame_q.msr;
    assign vector_o    = frame_q.vec;
    assign debug_o     = (state == MCE_DEBUG);
    assign checkstop_o = (state == MCE_CSTOP);

    // R5
    srr0_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mc_addr_phase_i || mc_data_phase_i) && state == MCE_RUN && msr_i[MSR_ME])
        |=> (take_o && srr0_o == $past(fault_ea_i)));

    // R9
    halted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != MCE_RUN) |=> (!take_o && $stable(srr0_o) && $stable(srr1_o)));

    // R7
    msr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_o & ~((32'd1 << MSR_LE) | (32'd1 << MSR_IP) | (32'd1 << MSR_ME))) == 32'd0);

    // R11
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (srr0_o == $past(srr0_o) || $past(!rst_n)));
endmodule

// File: tb/mce_ctrl_bench.sv
module mce_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_ph = 1'b0, d_ph = 1'b0, fetch = 1'b0, dbg_en = 1'b0;
    logic [31:0] ea = '0, msr = '0;
    logic [31:0] srr0, srr1, msr_n, vec;
    logic        take, dbg, dbg_ent, cstop, rreq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    mce_ctrl u_mce_ctrl (
        .clk(clk), .rst_n(rst_n),
        .mc_addr_phase_i(a_ph), .mc_data_phase_i(d_ph),
        .fault_fetch_i(fetch), .fault_ea_i(ea), .msr_i(msr), .dbg_en_i(dbg_en),
        .srr0_o(srr0), .srr1_o(srr1), .msr_o(msr_n), .vector_o(vec),
        .take_o(take), .debug_o(dbg), .debug_enter_o(dbg_ent),
        .checkstop_o(cstop), .reset_req_o(rreq)
    );

    function automatic logic [31:0] exp_srr1(input logic f, input logic [31:0] m);
        return {1'b0, f, 14'd0, m[15:0]};
    endfunction
    function automatic logic [31:0] exp_msr(input logic [31:0] m);
        logic [31:0] r;
        r = '0;
        r[6]  = m[6];
        r[12] = m[12];
        r[0]  = m[16];
        return r;
    endfunction
    function automatic logic [31:0] exp_vec(input logic [31:0] m);
        return m[6] ? 32'hFFF0_0200 : 32'h0000_0200;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one cycle of inputs, then look just after the edge
    task automatic step(input logic ap, input logic dp);
        @(negedge clk);
        a_ph = ap;
        d_ph = dp;
        @(posedge clk);
        #1;
        @(negedge clk);
        a_ph = 1'b0;
        d_ph = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(5ns * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] s0, s1;
        void'($urandom(32'd2024));
        do_reset();
        // R10
        chk("R10 reset frame", srr0 | srr1 | msr_n | vec, 32'd0);
        chk("R10 reset status", {take, dbg, dbg_ent, cstop, rreq}, 32'd0);

        // random taken interrupts: R1 R2 R5 R6 R7 R8
        for (int i = 0; i < 60; i++) begin
            logic [1:0] ph;
            ph = 2'(1 + $urandom_range(0, 2));
            ea = $urandom;
            msr = $urandom;
            msr[12] = 1'b1;
            if (i == 0) msr[6] = 1'b0;
            if (i == 1) msr[6] = 1'b1;
            fetch = 1'($urandom_range(0, 1));
            dbg_en = 1'($urandom_range(0, 1));
            @(negedge clk);
            a_ph = ph[0];
            d_ph = ph[1];
            @(posedge clk);
            #1;
            chk("R2 take pulse", take, 1);
            chk("R1 phase event", {dbg, cstop}, 0);
            chk("R5 srr0", srr0, ea);
            chk("R6 srr1", srr1, exp_srr1(fetch, msr));
            chk("R7 msr", msr_n, exp_msr(msr));
            chk("R8 vector", vec, exp_vec(msr));
            @(negedge clk);
            a_ph = 1'b0;
            d_ph = 1'b0;
            s0 = srr0;
            s1 = srr1;
            ea = ~ea;
            msr = ~msr;
            @(posedge clk);
            #1;
            // R2: single pulse; R11: hold
            chk("R2 pulse width", take, 0);
            chk("R11 hold srr0", srr0, s0);
            chk("R11 hold srr1", srr1, s1);
        end

        // debug entry, then ignored indications
        s0 = srr0;
        msr = 32'h0000_0000;
        dbg_en = 1'b1;
        step(1'b0, 1'b1);
        chk("R3 debug level", dbg, 1);
        chk("R3 no take", take, 0);
        @(posedge clk);
        #1;
        chk("R3 debug held", dbg, 1);
        msr[12] = 1'b1;
        ea = 32'hDEAD_BEEF;
        step(1'b1, 1'b1);
        chk("R9 ignored in debug", {take, dbg_ent, cstop}, 0);
        chk("R9 srr0 unchanged", srr0, s0);
        do_reset();
        chk("R10 debug cleared", dbg, 0);

        // checkstop entry
        msr = 32'h0000_FFFF;
        msr[12] = 1'b0;
        dbg_en = 1'b0;
        step(1'b1, 1'b0);
        chk("R4 checkstop level", cstop, 1);
        chk("R4 reset request", rreq, 1);
        chk("R4 no take", {take, dbg}, 0);
        @(posedge clk);
        #1;
        chk("R4 request pulse", rreq, 0);
        chk("R4 checkstop held", cstop, 1);
        msr[12] = 1'b1;
        dbg_en = 1'b1;
        step(1'b1, 1'b0);
        chk("R9 ignored in checkstop", {take, dbg, rreq}, 0);
        do_reset();
        chk("R10 checkstop cleared", cstop, 0);

        // after recovery, both phases at once yield one taken event
        msr = 32'h0001_1040;
        fetch = 1'b1;
        ea = 32'h0000_1234;
        step(1'b1, 1'b1);
        chk("R1 merged event", take, 1);
        chk("R8 high vector", vec, 32'hFFF0_0200);
        chk("R7 le from ile", msr_n, 32'h0000_1041);
        @(posedge clk);
        #1;
        chk("R1 single event", take, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule